// File: doc/BRIEF.md
# Pointer Memory Access Sequencer

This block carries out the memory-touching instructions of a compact 16-bit register machine. The machine has sixteen 16-bit registers, and register 0 serves as the accumulator. Each instruction names a pointer register. The block reads that register's value as a byte address, performs one or two byte transfers on a synchronous byte-wide memory port, and then writes back the accumulator and the moved pointer through a single register-file write port.

Loads and stores advance the pointer after each access. Pops and store-pops move it back before each access. As a result, the same register file can hold both byte stacks and 16-bit stacks. A single-byte load always clears the accumulator's upper byte.

Work is framed by a start/done handshake. `start` is taken only while the block is idle and only for a supported opcode. `done` pulses once when the last register write has landed. In the same cycle, `flag_upd` tells the surrounding core to clear its carry and to record register 0 as the holder of the latest result.

Top module: `ptr_mem_seq`

## Requirements
- R1: Opcode 4h: R0 becomes {8'h00, mem[P]}, where P is the old pointer value, and the pointer becomes P+1.
- R2: Opcode 5h: mem[P] receives R0[7:0], the pointer becomes P+1, and R0 is not changed.
- R3: Opcode 6h: R0 becomes {mem[P+1], mem[P]} and the pointer becomes P+2.
- R4: Opcode 7h: mem[P] receives R0[7:0], mem[P+1] receives R0[15:8], and the pointer becomes P+2.
- R5: Opcode 8h: the pointer becomes P-1 and R0 becomes {8'h00, mem[P-1]}.
- R6: Opcode 9h: the pointer becomes P-1 and mem[P-1] receives R0[7:0].
- R7: Opcode Ch: R0 becomes {mem[P-1], mem[P-2]} and the pointer becomes P-2. It undoes a 7h push on the same pointer.
- R8: Pointer and address arithmetic wraps modulo 2^16. For example, FFFFh+1 gives 0000h and 0000h-1 gives FFFFh.
- R9: `done` is high for exactly one cycle, in the cycle after the last register write. In that same cycle `flag_upd` is 1 and `prior_reg` is 0. Loads make two register writes and stores make one.
- R10: A `start` raised while `busy` is high is ignored and does not disturb the running operation.
- R11: A `start` carrying any opcode other than 4h, 5h, 6h, 7h, 8h, 9h or Ch is ignored: no busy, no done, no register or memory change.
- R12: The accumulator write comes before the pointer write. When the pointer is R0, R0 therefore ends holding the moved pointer value.
- R13: After reset, and whenever the block is idle, `busy`, `done`, `rf_we`, `mem_we` and `mem_re` are 0. Read and write are never driven in the same cycle, and no operation makes more than two memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation (taken only when idle) |
| op_code | input | 4 | Operation code (upper opcode nibble) |
| ptr_sel | input | 4 | Pointer register number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 4 | Register-file read address (pointer register) |
| rf_rdata | input | 16 | Register-file read data, combinational |
| acc_rdata | input | 16 | Current accumulator (R0) value |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data returns one cycle later |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| flag_upd | output | 1 | Clear carry and latch prior-result register |
| prior_reg | output | 4 | Register that now holds the prior result |

## Verification
The bench aims at the pointer moving past the ends of the 16-bit space in both directions. A design without wraparound would land on the wrong byte or leave a wrong pointer. It checks the byte order of the double pop, where swapped halves would come back from a push/pop round trip byte-reversed. It also checks the case where the pointer is R0 itself: a reversed write order would leave the loaded data in R0 instead of the moved pointer. Finally, it raises `start` in the middle of an operation and presents unsupported opcodes. A design that accepted either would run a second transfer, corrupting R2 or memory, or would pulse `done` without reason.

// File: rtl/pms_pkg.sv
package pms_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int REG_N  = 16;
    localparam int REG_AW = $clog2(REG_N);
    localparam int OP_W   = 4;
    localparam int OFF_W  = 3;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam logic [REG_AW-1:0] ACC_IDX = '0;

    typedef enum logic [OP_W-1:0] {
        OPC_LD_BYTE  = 4'h4,
        OPC_ST_BYTE  = 4'h5,
        OPC_LD_WORD  = 4'h6,
        OPC_ST_WORD  = 4'h7,
        OPC_POP_BYTE = 4'h8,
        OPC_PSH_DOWN = 4'h9,
        OPC_POP_WORD = 4'hC
    } opc_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_A1, ST_A2, ST_CAP, ST_WACC, ST_WPTR, ST_DONE
    } st_e;

    typedef struct packed {
        logic             is_load;
        logic             is_dbl;
        logic             hi_first;
        logic [OFF_W-1:0] off1;
        logic [OFF_W-1:0] off2;
        logic [OFF_W-1:0] delta;
    } opdesc_t;

    function automatic logic op_known(input logic [OP_W-1:0] c);
        case (c)
            OPC_LD_BYTE, OPC_ST_BYTE, OPC_LD_WORD, OPC_ST_WORD,
            OPC_POP_BYTE, OPC_PSH_DOWN, OPC_POP_WORD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // offsets are two's complement in OFF_W bits
    function automatic opdesc_t decode_op(input logic [OP_W-1:0] c);
        opdesc_t d;
        d = '0;
        case (c)
            OPC_LD_BYTE:  begin d.is_load = 1'b1; d.delta = 3'b001; end
            OPC_ST_BYTE:  begin d.delta = 3'b001; end
            OPC_LD_WORD:  begin d.is_load = 1'b1; d.is_dbl = 1'b1;
                                d.off2 = 3'b001; d.delta = 3'b010; end
            OPC_ST_WORD:  begin d.is_dbl = 1'b1;
                                d.off2 = 3'b001; d.delta = 3'b010; end
            OPC_POP_BYTE: begin d.is_load = 1'b1;
                                d.off1 = 3'b111; d.delta = 3'b111; end
            OPC_PSH_DOWN: begin d.off1 = 3'b111; d.delta = 3'b111; end
            OPC_POP_WORD: begin d.is_load = 1'b1; d.is_dbl = 1'b1; d.hi_first = 1'b1;
                                d.off1 = 3'b111; d.off2 = 3'b110; d.delta = 3'b110; end
            default: d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
    import pms_pkg::*;
#(
    parameter int RAW = REG_AW,
    parameter int CW  = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  op_code,
    input  logic [RAW-1:0] ptr_sel,
    output st_e            st,
    output opdesc_t        desc_q,
    output logic [RAW-1:0] sel_q,
    output logic           accept
);
    st_e st_nx;

    assign accept = (st == ST_IDLE) && start && op_known(op_code);

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (accept) st_nx = ST_A1;
            ST_A1:   st_nx = desc_q.is_dbl ? ST_A2 : (desc_q.is_load ? ST_CAP : ST_WPTR);
            ST_A2:   st_nx = desc_q.is_load ? ST_CAP : ST_WPTR;
            ST_CAP:  st_nx = ST_WACC;
            ST_WACC: st_nx = ST_WPTR;
            ST_WPTR: st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            desc_q <= '0;
            sel_q  <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                desc_q <= decode_op(op_code);
                sel_q  <= ptr_sel;
            end
        end
    end
endmodule

// File: rtl/pms_addr.sv
module pms_addr
    import pms_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [W-1:0]  ptr_in,
    input  st_e           st,
    input  logic [OW-1:0] off1,
    input  logic [OW-1:0] off2,
    input  logic [OW-1:0] delta,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  ptr_next
);
    logic [W-1:0]  ptr_q;
    logic [OW-1:0] off_sel;

    function automatic logic [W-1:0] sext(input logic [OW-1:0] o);
        return {{(W-OW){o[OW-1]}}, o};
    endfunction

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (accept) ptr_q <= ptr_in;
    end

    // sums truncate to W bits, giving modulo-2^W wrap
    assign off_sel  = (st == ST_A2) ? off2 : off1;
    assign mem_addr = ptr_q + sext(off_sel);
    assign ptr_next = ptr_q + sext(delta);
endmodule

// File: rtl/pms_bytes.sv
module pms_bytes
    import pms_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NB = NBYTES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [NB*BW-1:0] acc_in,
    input  st_e             st,
    input  logic            is_load,
    input  logic            is_dbl,
    input  logic            hi_first,
    input  logic [BW-1:0]   mem_rdata,
    output logic [BW-1:0]   st_byte,
    output logic [NB*BW-1:0] acc_new
);
    localparam int SW = (NB > 1) ? $clog2(NB) : 1;

    logic [NB*BW-1:0] acc_q;
    logic             rd_pend;
    logic [SW-1:0]    rd_slot;
    logic [BW-1:0]    slot [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rd_pend <= 1'b0;
            rd_slot <= '0;
        end else begin
            if (accept) acc_q <= acc_in;
            rd_pend <= is_load && ((st == ST_A1) || (st == ST_A2));
            rd_slot <= (st == ST_A2) ? SW'(1) : SW'(0);
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                slot[g] <= '0;
            else if (rd_pend && rd_slot == SW'(g))  slot[g] <= mem_rdata;
        end
    end

    assign st_byte = (st == ST_A2) ? acc_q[2*BW-1:BW] : acc_q[BW-1:0];

    always_comb begin
        acc_new = '0;
        if (!is_dbl)       acc_new[BW-1:0] = slot[0];
        else if (hi_first) acc_new = {slot[0], slot[1]};
        else               acc_new = {slot[1], slot[0]};
    end
endmodule

// File: rtl/ptr_mem_seq.sv
module ptr_mem_seq
    import pms_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int BW  = BYTE_W,
    parameter int RAW = REG_AW,
    parameter int CW  = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  op_code,
    input  logic [RAW-1:0] ptr_sel,
    output logic           busy,
    output logic           done,
    output logic [RAW-1:0] rf_raddr,
    input  logic [W-1:0]   rf_rdata,
    input  logic [W-1:0]   acc_rdata,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [W-1:0]   rf_wdata,
    output logic [W-1:0]   mem_addr,
    output logic           mem_we,
    output logic           mem_re,
    output logic [BW-1:0]  mem_wdata,
    input  logic [BW-1:0]  mem_rdata,
    output logic           flag_upd,
    output logic [RAW-1:0] prior_reg
);
    st_e            st;
    opdesc_t        desc_q;
    logic [RAW-1:0] sel_q;
    logic           accept;
    logic [W-1:0]   ptr_next;
    logic [W-1:0]   acc_new;
    logic           in_access;

    pms_ctrl #(.RAW(RAW), .CW(CW)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .ptr_sel(ptr_sel),
        .st(st), .desc_q(desc_q), .sel_q(sel_q), .accept(accept)
    );

    pms_addr #(.W(W), .OW(OFF_W)) addr_i (
        .clk(clk), .rst(rst), .accept(accept), .ptr_in(rf_rdata), .st(st),
        .off1(desc_q.off1), .off2(desc_q.off2), .delta(desc_q.delta),
        .mem_addr(mem_addr), .ptr_next(ptr_next)
    );

    pms_bytes #(.BW(BW), .NB(W / BW)) bytes_i (
        .clk(clk), .rst(rst), .accept(accept), .acc_in(acc_rdata), .st(st),
        .is_load(desc_q.is_load), .is_dbl(desc_q.is_dbl), .hi_first(desc_q.hi_first),
        .mem_rdata(mem_rdata), .st_byte(mem_wdata), .acc_new(acc_new)
    );

    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_DONE);
    assign in_access = (st == ST_A1) || (st == ST_A2);
    assign mem_re    = in_access && desc_q.is_load;
    assign mem_we    = in_access && !desc_q.is_load;
    assign rf_raddr  = busy ? sel_q : ptr_sel;

    // accumulator first, pointer last: pointer wins when it is R0
    assign rf_we     = (st == ST_WACC) || (st == ST_WPTR);
    assign rf_waddr  = (st == ST_WACC) ? RAW'(ACC_IDX) : sel_q;
    assign rf_wdata  = (st == ST_WACC) ? acc_new : ptr_next;

    assign flag_upd  = done;
    assign prior_reg = RAW'(ACC_IDX);
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic rf_we,
    input logic mem_we,
    input logic mem_re,
    input logic flag_upd
);
    logic [2:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)                      acc_cnt <= '0;
        else if ((mem_we || mem_re) && acc_cnt != 3'd7) acc_cnt <= acc_cnt + 3'd1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rf_we)) else $error("done without prior register write"); // R9
    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> flag_upd) else $error("flag update missing at done"); // R9
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)) else $error("busy rose without start"); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(rf_we || mem_we || mem_re)) else $error("activity while idle"); // R13
    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)) else $error("read and write together"); // R13
    AST_ACCESS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        acc_cnt <= 3'd2) else $error("more than two memory accesses"); // R13
endmodule

bind ptr_mem_seq pms_checker chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rf_we(rf_we), .mem_we(mem_we), .mem_re(mem_re), .flag_upd(flag_upd)
);

// File: tb/ptr_mem_seq_tb_top.sv
module ptr_mem_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  ptr_sel = '0;
    logic        busy, done, rf_we, mem_we, mem_re, flag_upd;
    logic [3:0]  rf_raddr, rf_waddr, prior_reg;
    logic [15:0] rf_rdata, acc_rdata, rf_wdata, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [15:0] regs [16];
    logic [7:0]  mem  [256];
    logic [15:0] init_regs [16];
    logic [7:0]  init_mem  [256];
    logic        load_init = 1'b0;
    logic [7:0]  rdq;

    int total = 0;
    int fails = 0;
    bit fin = 0;

    always #2 clk = ~clk;

    ptr_mem_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .ptr_sel(ptr_sel),
        .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .acc_rdata(acc_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .flag_upd(flag_upd), .prior_reg(prior_reg)
    );

    // register file and memory models (memory index uses the low address byte)
    assign rf_rdata  = regs[rf_raddr];
    assign acc_rdata = regs[0];
    assign mem_rdata = rdq;

    always @(posedge clk) begin
        if (load_init) begin
            regs <= init_regs;
            mem  <= init_mem;
        end else begin
            if (rf_we)  regs[rf_waddr] <= rf_wdata;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_re) rdq <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic setup(input logic [3:0] n, input logic [15:0] ptr, input logic [15:0] acc);
        for (int k = 0; k < 16; k++) init_regs[k] = 16'(k * 16'h1111) ^ 16'h0F0F;
        init_regs[0] = acc;
        init_regs[n] = ptr;
        for (int i = 0; i < 256; i++) init_mem[i] = 8'(i * 37 + 11);
        @(negedge clk) load_init = 1'b1;
        @(negedge clk) load_init = 1'b0;
    endtask

    task automatic compare_state(input logic [15:0] er [16], input logic [7:0] em [256],
                                 input string tag);
        int bad_r = -1;
        int bad_m = -1;
        for (int k = 0; k < 16; k++) if (bad_r < 0 && regs[k] !== er[k]) bad_r = k;
        for (int i = 0; i < 256; i++) if (bad_m < 0 && mem[i] !== em[i]) bad_m = i;
        check(bad_r < 0, tag, "register file", (bad_r < 0) ? 32'h0 : {16'(bad_r), regs[bad_r]},
              (bad_r < 0) ? 32'h0 : {16'(bad_r), er[bad_r]});
        check(bad_m < 0, tag, "memory", (bad_m < 0) ? 32'h0 : {24'(bad_m), mem[bad_m]},
              (bad_m < 0) ? 32'h0 : {24'(bad_m), em[bad_m]});
    endtask

    // runs one operation from the current model state; poke raises start mid-operation
    task automatic run_op(input logic [3:0] op, input logic [3:0] n, input string tag,
                          input bit poke);
        logic [15:0] er [16];
        logic [7:0]  em [256];
        logic [15:0] p, a, pe, acce;
        bit ld;
        int writes = 0;
        bit got = 0;
        er = regs; em = mem;
        p = er[n]; a = er[0]; ld = 1'b1; acce = a; pe = p;
        case (op)
            4'h4: begin acce = {8'h00, em[p[7:0]]}; pe = p + 16'd1; end
            4'h5: begin em[p[7:0]] = a[7:0]; pe = p + 16'd1; ld = 1'b0; end
            4'h6: begin acce = {em[8'(p + 16'd1)], em[p[7:0]]}; pe = p + 16'd2; end
            4'h7: begin em[p[7:0]] = a[7:0]; em[8'(p + 16'd1)] = a[15:8];
                        pe = p + 16'd2; ld = 1'b0; end
            4'h8: begin pe = p - 16'd1; acce = {8'h00, em[pe[7:0]]}; end
            4'h9: begin pe = p - 16'd1; em[pe[7:0]] = a[7:0]; ld = 1'b0; end
            default: begin acce = {em[8'(p - 16'd1)], em[8'(p - 16'd2)]}; pe = p - 16'd2; end
        endcase
        if (ld) er[0] = acce;
        er[n] = pe;
        @(negedge clk) begin start = 1'b1; op_code = op; ptr_sel = n; end
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (poke && i == 1) begin start = 1'b1; op_code = 4'h5; ptr_sel = 4'd2; end
            if (poke && i == 3) start = 1'b0;
            if (done) got = 1;
            else begin
                if (rf_we) writes++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        check(got, "R9", "done seen", 32'(got), 32'h1);
        check(flag_upd === 1'b1 && prior_reg === 4'h0, "R9", "flag/prior at done",
              {flag_upd, prior_reg}, 32'h10);
        check(writes == (ld ? 2 : 1), "R9", "register writes before done",
              32'(writes), ld ? 32'd2 : 32'd1);
        compare_state(er, em, tag);
        @(negedge clk);
        check(done === 1'b0, "R9", "done one cycle", 32'(done), 32'h0);
    endtask

    function automatic string tag_for(input logic [3:0] op, input logic [3:0] n,
                                      input logic [15:0] p);
        if (n == 4'd0)                      return "R12";
        if (p == 16'hFFFF || p == 16'h0000) return "R8";
        case (op)
            4'h4: return "R1";
            4'h5: return "R2";
            4'h6: return "R3";
            4'h7: return "R4";
            4'h8: return "R5";
            4'h9: return "R6";
            default: return "R7";
        endcase
    endfunction

    // {op, pointer reg, pointer value, accumulator value}
    localparam logic [39:0] VEC [12] = '{
        {4'h4, 4'd3,  16'h0010, 16'hABCD},
        {4'h5, 4'd4,  16'h0020, 16'h5A77},
        {4'h6, 4'd5,  16'h0030, 16'h0000},
        {4'h7, 4'd6,  16'h0040, 16'hBEEF},
        {4'h8, 4'd7,  16'h0050, 16'h1111},
        {4'h9, 4'd8,  16'h0060, 16'hC3A5},
        {4'hC, 4'd9,  16'h0070, 16'h2222},
        {4'h6, 4'd10, 16'hFFFF, 16'h0000},
        {4'h8, 4'd11, 16'h0000, 16'h9999},
        {4'h7, 4'd1,  16'hFFFF, 16'h1234},
        {4'h4, 4'd0,  16'h0033, 16'h0033},
        {4'h5, 4'd0,  16'h0044, 16'h0044}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rf_we && !mem_we && !mem_re, "R13", "idle after reset",
              {busy, done, rf_we, mem_we, mem_re}, 32'h0);

        for (int v = 0; v < 12; v++) begin
            setup(VEC[v][35:32], VEC[v][31:16], VEC[v][15:0]);
            run_op(VEC[v][39:36], VEC[v][35:32],
                   tag_for(VEC[v][39:36], VEC[v][35:32], VEC[v][31:16]), 1'b0);
        end

        // 16-bit push then pop on the same pointer restores the accumulator
        setup(4'd5, 16'h0080, 16'hAA12);
        run_op(4'h7, 4'd5, "R4", 1'b0);
        @(negedge clk) begin init_regs = regs; init_mem = mem; init_regs[0] = 16'h0000; load_init = 1'b1; end
        @(negedge clk) load_init = 1'b0;
        run_op(4'hC, 4'd5, "R7", 1'b0);
        check(regs[0] === 16'hAA12, "R7", "round trip value", 32'(regs[0]), 32'hAA12);
        check(regs[5] === 16'h0080, "R7", "round trip pointer", 32'(regs[5]), 32'h0080);

        // unsupported opcodes
        for (int c = 0; c < 16; c++) begin
            if (c == 4 || c == 5 || c == 6 || c == 7 || c == 8 || c == 9 || c == 12) continue;
            setup(4'd3, 16'h0010, 16'h4321);
            begin
                logic [15:0] er [16];
                logic [7:0]  em [256];
                bit act = 0;
                er = regs; em = mem;
                @(negedge clk) begin start = 1'b1; op_code = 4'(c); ptr_sel = 4'd3; end
                @(negedge clk) start = 1'b0;
                for (int i = 0; i < 10; i++) begin
                    if (busy || done || rf_we || mem_we || mem_re) act = 1;
                    @(negedge clk);
                end
                check(!act, "R11", "no activity on unsupported opcode", 32'(act), 32'h0);
                compare_state(er, em, "R11");
            end
        end

        // start while busy is ignored
        setup(4'd5, 16'h0030, 16'h7777);
        run_op(4'h6, 4'd5, "R10", 1'b1);
        begin
            bit act = 0;
            for (int i = 0; i < 12; i++) begin
                if (busy || done) act = 1;
                @(negedge clk);
            end
            check(!act, "R10", "no second operation", 32'(act), 32'h0);
        end

        fin = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!fin) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule